// File: doc/BRIEF.md
# Programmable peripheral clock divider

This block turns the processor clock into a peripheral clock enable. Its output is a single-cycle pulse, synchronous to the processor clock. Peripherals that qualify their registers with it run at one, one half or one quarter of the processor rate. A small control register on a simple peripheral register port selects the rate. Lowering the peripheral rate saves power when no peripheral needs the full processor speed.

The register holds a 2-bit ratio code. The encoding is not ordered by speed. Out of reset the block runs at the slowest ratio, so the bus that carries its own control register always works. A write of the unused code is dropped, and the previous ratio stays in force. A new code does not cut a running period short. It is picked up only when the current divided period ends.

The control pins are plain single-cycle strobes. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `pclk_divider`

## Requirements
- R1: While `rst_n` is low, `pclk_en` is low and the ratio code is 00. After release, the first `pclk_en` pulse is high in the cycle after the third rising clock edge at which `rst_n` is high.
- R2: Ratio code 01 gives a `pclk_en` pulse on every processor clock cycle (spacing 1).
- R3: Ratio code 10 gives a one-cycle `pclk_en` pulse every 2 cycles.
- R4: Ratio code 00 gives a one-cycle `pclk_en` pulse every 4 cycles.
- R5: A write whose bits 1:0 are 11 is discarded. The stored code and the pulse spacing keep their previous values.
- R6: A write with bits 1:0 other than 11 stores those two bits as the new code. The values written to bits 7:2 have no effect.
- R7: While `reg_sel` is high, `reg_rdata` returns the stored code in bits 1:0 and zero in bits 7:2. While `reg_sel` is low, `reg_rdata` is zero.
- R8: A new code takes effect only at the end of the divided period in progress. The pulse spacing that ends at the first pulse after the write still equals the old ratio. Every later spacing equals the new ratio.
- R9: A write is captured only on a rising edge where both `reg_sel` and `reg_we` are high. Strobing `reg_we` without `reg_sel`, or reading with `reg_we` low, leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select for the control register |
| reg_we | input | 1 | Write strobe, qualified by `reg_sel` |
| reg_wdata | input | 8 | Write data; bits 1:0 carry the ratio code |
| reg_rdata | output | 8 | Read data; current code in bits 1:0 |
| pclk_en | output | 1 | Peripheral clock-enable pulse |

## Verification
The bench steps through a sequence of writes that visits every pair of ratios. For each write it measures the spacing between enable pulses on both sides of the change. A design that applied the code at once would show a shortened or stretched spacing at the first pulse after the write, and would fail R8.

Writes of the unused code 11 are mixed into the sequence, some with the upper bits set. A design that stored 11, or that decoded it as some ratio, would change the readback or the spacing. A design that let bits 7:2 disturb the field would fail R6.

Strobes without select catch a decoder that ignores `reg_sel`. The reset checks catch a wrong default ratio, and a counter that starts at the wrong phase and so misplaces the first pulse.

// File: rtl/pclkdiv_pkg.sv
package pclkdiv_pkg;

  localparam int unsigned CODE_W  = 2;
  localparam int unsigned PHASE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    RATIO_QUARTER = 2'b00,
    RATIO_FULL    = 2'b01,
    RATIO_HALF    = 2'b10,
    RATIO_UNUSED  = 2'b11
  } ratio_e;

  // Last phase count of one divided period for a ratio code.
  function automatic logic [PHASE_W-1:0] last_phase(input ratio_e code);
    case (code)
      RATIO_FULL: last_phase = PHASE_W'(0);
      RATIO_HALF: last_phase = PHASE_W'(1);
      default:    last_phase = PHASE_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/pclkdiv_ctrl_reg.sv
module pclkdiv_ctrl_reg
  import pclkdiv_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ratio_e            code
);

  localparam int unsigned PAD_W = DATA_W - CODE_W;

  ratio_e code_q;
  ratio_e wr_code;
  logic   wr_ok;

  assign wr_code = ratio_e'(wdata[CODE_W-1:0]);
  assign wr_ok   = sel && we && (wr_code != RATIO_UNUSED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RATIO_QUARTER;
    end else if (wr_ok) begin
      code_q <= wr_code;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata = sel ? {{PAD_W{1'b0}}, code_q} : '0;
    end else begin : g_nopad
      assign rdata = sel ? code_q : '0;
    end
  endgenerate

  assign code = code_q;

endmodule

// File: rtl/pclkdiv_pulse_gen.sv
module pclkdiv_pulse_gen
  import pclkdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_e prog_code,
  output ratio_e act_code,
  output logic   pulse
);

  logic [PHASE_W-1:0] phase_q;
  ratio_e             act_q;
  logic               wrap;

  assign wrap = (phase_q == last_phase(act_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      act_q   <= RATIO_QUARTER;
    end else if (wrap) begin
      phase_q <= '0;
      act_q   <= prog_code;
    end else begin
      phase_q <= phase_q + PHASE_W'(1);
    end
  end

  assign pulse    = wrap;
  assign act_code = act_q;

endmodule

// File: rtl/pclk_divider.sv
module pclk_divider
  import pclkdiv_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pclk_en
);

  ratio_e prog_code;
  ratio_e act_code;

  pclkdiv_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (reg_sel),
    .we    (reg_we),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .code  (prog_code)
  );

  pclkdiv_pulse_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_code (prog_code),
    .act_code  (act_code),
    .pulse     (pclk_en)
  );

endmodule

// File: rtl/pclkdiv_chk.sv
module pclkdiv_chk
  import pclkdiv_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input ratio_e            prog_code,
  input ratio_e            act_code,
  input logic              pclk_en
);

  logic [PHASE_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap_q <= '0;
    else if (pclk_en) gap_q <= '0;
    else              gap_q <= gap_q + PHASE_W'(1);
  end

  // R1
  always_comb begin
    if (!rst_n) begin
      quiet_in_reset_chk: assert (!pclk_en);
    end
  end

  // R5
  unused_code_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_we && reg_wdata[1:0] == 2'b11) |=> $stable(prog_code));

  // R6
  code_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_we && reg_wdata[1:0] != 2'b11) |=> (prog_code == $past(reg_wdata[1:0])));

  // R9
  no_strobe_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_sel && reg_we) |=> $stable(prog_code));

  // R8
  ratio_held_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pclk_en |=> $stable(act_code));

  // R4
  pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_en |-> (gap_q == last_phase(act_code)));

endmodule

bind pclk_divider pclkdiv_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_sel   (reg_sel),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .prog_code (prog_code),
  .act_code  (act_code),
  .pclk_en   (pclk_en)
);

// File: tb/test_pclk_divider.sv
module test_pclk_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       pclk_en;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int cyc = 0;
  int last_pulse = 0;
  int last_gap = 0;
  int pulse_cnt = 0;
  int first_cyc = 0;

  always #4 clk = ~clk;

  pclk_divider i_pclk_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pclk_en   (pclk_en)
  );

  // Pulse monitor: samples 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      cyc = 0; last_pulse = 0; pulse_cnt = 0;
    end else begin
      cyc = cyc + 1;
      if (pclk_en) begin
        last_gap = cyc - last_pulse;
        last_pulse = cyc;
        pulse_cnt = pulse_cnt + 1;
        if (pulse_cnt == 1) first_cyc = cyc;
      end
    end
  end

  // {write data, expected spacing after the change}
  localparam logic [10:0] VEC [12] = '{
    {8'h01, 3'd1}, {8'h02, 3'd2}, {8'h03, 3'd2}, {8'h00, 3'd4},
    {8'hFF, 3'd4}, {8'h01, 3'd1}, {8'hFE, 3'd2}, {8'h03, 3'd2},
    {8'hFC, 3'd4}, {8'h02, 3'd2}, {8'h01, 3'd1}, {8'h00, 3'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, output int n0);
    @(negedge clk);
    n0 = pulse_cnt;
    reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk);
    reg_sel = 1'b1;
    #1 v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic wait_pulses(input int target);
    while (pulse_cnt < target) @(negedge clk);
  endtask

  function automatic string tag_for(input int div);
    if (div == 1) return "R2";
    if (div == 2) return "R3";
    return "R4";
  endfunction

  initial begin
    logic [7:0] rb;
    int n0;
    int cur_div;
    int cur_code;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 en in reset", int'(pclk_en), 0);
    reg_sel = 1'b1;
    #1 chk("R1 code in reset", int'(reg_rdata), 0);
    reg_sel = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_pulses(1);
    chk("R1 first pulse cycle", first_cyc, 3);
    wait_pulses(2);
    chk("R4 spacing after reset", last_gap, 4);
    // R7: select low gives zero read data
    chk("R7 rdata without select", int'(reg_rdata), 0);

    cur_div = 4;
    cur_code = 0;
    for (int i = 0; i < 12; i++) begin
      logic [7:0] d;
      int nd;
      string t;
      d  = VEC[i][10:3];
      nd = int'(VEC[i][2:0]);
      if (d[1:0] == 2'b11) t = "R5";
      else if (d[7:2] != 6'd0) t = "R6";
      else t = tag_for(nd);
      wr(d, n0);
      wait_pulses(n0 + 1);
      chk("R8 old spacing kept", last_gap, cur_div);
      wait_pulses(n0 + 2);
      chk(t, last_gap, nd);
      wait_pulses(n0 + 3);
      chk(tag_for(nd), last_gap, nd);
      if (d[1:0] != 2'b11) cur_code = int'(d[1:0]);
      rd(rb);
      chk("R7 readback", int'(rb), cur_code);
      cur_div = nd;
    end

    // R9: strobe without select, then read with we low
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = 8'h01;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 8'h00;
    rd(rb);
    chk("R9 write without select", int'(rb), cur_code);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_wdata = 8'h02;
    @(negedge clk);
    reg_sel = 1'b0; reg_wdata = 8'h00;
    rd(rb);
    chk("R9 select without write", int'(rb), cur_code);
    n0 = pulse_cnt;
    wait_pulses(n0 + 2);
    chk("R9 spacing unchanged", last_gap, cur_div);

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule